// File: doc/BRIEF.md
# Single-Bit Alias Access Bridge

This bridge sits between a bus master and a word-wide memory or peripheral slave. It watches every data request for addresses inside two 32 MB alias windows, which begin at 0x22000000 and 0x42000000. Each 32-bit alias word stands for one bit of a 1 MB target window: 0x20000000–0x200FFFFF or 0x40000000–0x400FFFFF. The bridge turns the alias address into the address of the target word and a bit index.

An alias load reads the target word and returns the chosen bit as a 0 or 1 in bit 0. An alias store does an atomic read-modify-write of the target word. The read beat and the write beat are both marked locked, and they are issued back to back, so the master cannot slip another transfer between them. Instruction fetches, and all data accesses outside the alias windows, reach the slave with the address, size and data unchanged.

The upstream request uses valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The bridge holds one request at a time: `req_ready` is high only while no downstream access is in flight. The master must keep its request fields stable until the request is taken. The response cannot be stalled. It is a single-cycle `rsp_valid` pulse, and the master must take it in that cycle.

Downstream, the bridge raises `mem_valid` and keeps every field steady until `mem_ready` completes the beat. Read data is taken from `mem_rdata` in the cycle the beat completes. Write data always travels in its natural lanes of the 32-bit word, in little-endian order.

Top module: `bitband_bridge`

## Requirements
- R1: A data request outside the alias windows is forwarded once, with the same address, size, write flag and write data. A read returns the slave's 32-bit word unchanged. A write returns read data of zero.
- R2: An address is an alias address when bits [31:28] are 0x2 or 0x4 and bits [27:25] equal 3'b001. Its target word address is {addr[31:28], 8'h00, addr[24:7], 2'b00}, and its bit index is addr[6:2].
- R3: An alias read issues one unlocked read of the target. The response has the selected bit in bit 0 and zero in bits [31:1].
- R4: An alias write reads the target word and then writes it back with only the selected bit replaced by write-data bit 0. Write-data bits [31:1] are ignored.
- R5: Both beats of an alias write carry `mem_lock` high. The write beat is presented in the cycle right after the locked read completes, to the same address. `mem_lock` is low on every other beat.
- R6: `req_ready` is low whenever `mem_valid` is high. The next request is taken only after the final beat of the current one has completed.
- R7: Sizes are encoded as 0 = byte, 1 = halfword, 2 = word. An alias access of size byte or halfword produces target beats of the same size, addressed to the byte (bit index / 8) or to the halfword (bit index / 16) that holds the bit.
- R8: An alias data access whose address bits [1:0] are not zero produces no downstream beat. It is answered in the next cycle with `rsp_err` high and read data of zero.
- R9: An instruction fetch (`req_fetch` high) inside an alias window is forwarded unchanged, as in R1.
- R10: During and right after reset, `req_ready` is high, and `mem_valid`, `mem_lock` and `rsp_valid` are low.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write`, `mem_size` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, lane-aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Misaligned alias access |
| rsp_rdata | output | 32 | Read result |
| mem_valid | output | 1 | Downstream beat present |
| mem_ready | input | 1 | Slave completes the beat |
| mem_write | output | 1 | Downstream write |
| mem_lock | output | 1 | Beat belongs to an atomic pair |
| mem_size | output | 2 | Downstream size |
| mem_addr | output | 32 | Downstream byte address |
| mem_wdata | output | 32 | Downstream write data |
| mem_rdata | input | 32 | Slave read data, valid with `mem_ready` |

## Verification
The bench builds the bridge with its default parameters: a 20-bit window, which gives the 32 MB alias spans, and the two window tags 0x2 and 0x4. With these values the bench can reach the worked value 0x3355AACC in the first window and bit 31 of a word in the second window. The slave model drops `mem_ready` in a pseudo-random pattern. This stalls both beats of the locked pair, so the hold, back-to-back and ready-low rules are exercised under back-pressure rather than only with an always-ready slave.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ALIAS_RD,
    ST_LOCK_RD,
    ST_LOCK_WR
  } bb_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode #(
  parameter int          WIN_BITS = 20,
  parameter int          NUM_WIN  = 2,
  parameter logic [NUM_WIN*4-1:0] WIN_TAGS = 8'h42
) (
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic        fetch,
  output logic        hit,
  output logic        misalign,
  output logic [31:0] tgt_addr,
  output logic [4:0]  bit_idx
);
  import bb_pkg::*;
  localparam int ALIAS_LSB = WIN_BITS + 5;
  localparam int SEL_W     = 28 - ALIAS_LSB;

  logic [NUM_WIN-1:0] win_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w] = (addr[31:28] == WIN_TAGS[w*4 +: 4]) &&
                        (addr[27:ALIAS_LSB] == SEL_W'(1));
  end

  logic [31:0] word_addr;
  logic [31:0] lane_ofs;

  assign hit       = (|win_hit) && !fetch;
  assign misalign  = addr[1:0] != 2'b00;
  assign bit_idx   = addr[6:2];
  assign word_addr = {addr[31:28], {(28-WIN_BITS){1'b0}}, addr[ALIAS_LSB-1:7], 2'b00};

  always_comb begin
    case (size)
      SZ_BYTE: lane_ofs = {30'd0, addr[6:5]};
      SZ_HALF: lane_ofs = {30'd0, addr[6], 1'b0};
      default: lane_ofs = 32'd0;
    endcase
  end

  assign tgt_addr = word_addr | lane_ofs;
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [IDX_W-1:0]  sel,
  input  logic              new_bit,
  output logic              bit_out,
  output logic [DATA_W-1:0] word_out
);
  assign bit_out = word_in[sel];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign word_out[i] = (sel == IDX_W'(i)) ? new_bit : word_in[i];
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int                WIN_BITS = 20,
  parameter int                NUM_WIN  = 2,
  parameter logic [NUM_WIN*4-1:0] WIN_TAGS = 8'h42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_fetch,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic        mem_lock,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  import bb_pkg::*;

  bb_state_t   state_q;
  logic [31:0] addr_q, wdata_q, rd_q;
  logic [1:0]  size_q;
  logic        write_q;
  logic [4:0]  bit_q;

  logic        dec_hit, dec_mis;
  logic [31:0] dec_tgt;
  logic [4:0]  dec_bit;

  bb_alias_decode #(.WIN_BITS(WIN_BITS), .NUM_WIN(NUM_WIN), .WIN_TAGS(WIN_TAGS)) u_dec (
    .addr(req_addr), .size(req_size), .fetch(req_fetch),
    .hit(dec_hit), .misalign(dec_mis), .tgt_addr(dec_tgt), .bit_idx(dec_bit)
  );

  logic        rd_bit;
  logic [31:0] merged;
  logic        sel_bit_live;
  logic [31:0] merged_unused;

  bb_bit_merge #(.DATA_W(32)) u_merge (
    .word_in(rd_q), .sel(bit_q), .new_bit(wdata_q[0]),
    .bit_out(rd_bit), .word_out(merged)
  );

  bb_bit_merge #(.DATA_W(32)) u_extract (
    .word_in(mem_rdata), .sel(bit_q), .new_bit(1'b0),
    .bit_out(sel_bit_live), .word_out(merged_unused)
  );

  logic accept, beat_done;
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_valid = (state_q != ST_IDLE);
  assign beat_done = mem_valid && mem_ready;
  assign mem_addr  = addr_q;
  assign mem_size  = size_q;
  assign mem_lock  = (state_q == ST_LOCK_RD) || (state_q == ST_LOCK_WR);
  assign mem_write = (state_q == ST_PASS) ? write_q : (state_q == ST_LOCK_WR);
  assign mem_wdata = (state_q == ST_LOCK_WR) ? merged : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_q      <= '0;
      size_q    <= SZ_WORD;
      write_q   <= 1'b0;
      bit_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          size_q  <= req_size;
          write_q <= req_write;
          wdata_q <= req_wdata;
          bit_q   <= dec_bit;
          if (dec_hit && dec_mis) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end else if (dec_hit) begin
            addr_q  <= dec_tgt;
            state_q <= req_write ? ST_LOCK_RD : ST_ALIAS_RD;
          end else begin
            addr_q  <= req_addr;
            state_q <= ST_PASS;
          end
        end
        ST_PASS: if (beat_done) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= write_q ? 32'd0 : mem_rdata;
          state_q   <= ST_IDLE;
        end
        ST_ALIAS_RD: if (beat_done) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= {31'd0, sel_bit_live};
          state_q   <= ST_IDLE;
        end
        ST_LOCK_RD: if (beat_done) begin
          rd_q    <= mem_rdata;
          state_q <= ST_LOCK_WR;
        end
        ST_LOCK_WR: if (beat_done) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= 32'd0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Assertions next to the logic they guard
  assert_lock_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && mem_lock && !mem_write) |=>
      (mem_valid && mem_write && mem_lock && $stable(mem_addr)));

  assert_busy_no_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  assert_hold_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) &&
       $stable(mem_size) && $stable(mem_wdata)));

  assert_misalign_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_hit && dec_mis) |=> (rsp_valid && rsp_err && !mem_valid));

  assert_single_bit_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_lock) |-> ($countones(mem_wdata ^ rd_q) <= 1));

  assert_alias_rd_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALIAS_RD && beat_done) |=> (rsp_valid && rsp_rdata[31:1] == 31'd0));

  logic unused_ok;
  assign unused_ok = rd_bit ^ (|merged_unused);
endmodule

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_fetch = 0;
  logic [1:0]  req_size = 2;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write, mem_lock;
  logic        mem_ready = 0;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  bitband_bridge dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fetch(req_fetch), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_lock(mem_lock),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;

  // Slave model: 64 words indexed by {addr[30], addr[25], addr[5:2]}
  logic [31:0] store [64];
  logic [7:0]  lfsr = 8'h5A;
  function automatic int idx_of(logic [31:0] a);
    return int'({a[30], a[25], a[5:2]});
  endfunction
  assign mem_rdata = store[idx_of(mem_addr)];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= lfsr[0] | lfsr[2];
    if (mem_valid && mem_ready && mem_write) begin
      for (int b = 0; b < 4; b++) begin
        logic en;
        case (mem_size)
          2'd0: en = (b == int'(mem_addr[1:0]));
          2'd1: en = ((b >> 1) == int'(mem_addr[1]));
          default: en = 1'b1;
        endcase
        if (en) store[idx_of(mem_addr)][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end
    end
  end

  // Downstream monitor: last beat, beat count, rule violations
  logic [31:0] last_addr;
  logic [1:0]  last_size;
  int beats = 0, lock_bad = 0, lock_pairs = 0, ready_bad = 0, hold_bad = 0;
  logic        after_lock_rd = 0, stalled = 0;
  logic [31:0] lock_addr, hold_addr;

  always @(negedge clk) if (rst_n) begin
    if (mem_valid && req_ready) ready_bad++;
    if (stalled && !(mem_valid && mem_addr == hold_addr)) hold_bad++;
    stalled   = mem_valid && !mem_ready;
    hold_addr = mem_addr;
    if (after_lock_rd && !mem_valid) lock_bad++;
    if (mem_valid && mem_ready) begin
      beats++;
      last_addr = mem_addr;
      last_size = mem_size;
      if (after_lock_rd) begin
        if (!(mem_write && mem_lock && mem_addr == lock_addr)) lock_bad++;
        else lock_pairs++;
        after_lock_rd = 0;
      end else if (mem_lock) begin
        if (mem_write) lock_bad++;
        after_lock_rd = 1;
        lock_addr     = mem_addr;
      end
    end
  end

  // Scoreboard
  typedef struct { logic [31:0] data; logic err; string tag; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) if (rsp_valid) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected response rdata=%h expected none", rsp_rdata);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      if (rsp_rdata !== e.data || rsp_err !== e.err) begin
        errors++;
        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                 e.tag, rsp_rdata, rsp_err, e.data, e.err);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic fe, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] wd,
                      input logic [31:0] ed, input logic ee, input string tag);
    exp_t e;
    e.data = ed; e.err = ee; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_fetch = fe; req_size = sz;
    req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #2 req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) store[i] = 32'd0;
    store[18] = 32'hA5A5_0F0F;  // raw word seen at 0x22000008 by a fetch
    repeat (3) @(negedge clk);
    check(req_ready && !mem_valid && !mem_lock && !rsp_valid, "R10 reset state",
          {mem_lock, rsp_valid, mem_valid, req_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !mem_valid, "R10 after reset", {mem_valid, req_ready}, 32'h1);

    xfer(1, 0, 2, 32'h2000_0000, 32'h3355_AACC, 0, 0, "R1 plain write");
    check(last_addr == 32'h2000_0000 && last_size == 2, "R1 plain addr", last_addr, 32'h2000_0000);
    xfer(0, 0, 2, 32'h2000_0000, 0, 32'h3355_AACC, 0, "R1 plain read");
    xfer(0, 0, 2, 32'h2200_0008, 0, 32'h1, 0, "R3 alias read bit2");
    check(last_addr == 32'h2000_0000, "R2 alias target addr", last_addr, 32'h2000_0000);
    xfer(0, 0, 2, 32'h2200_0004, 0, 32'h0, 0, "R3 alias read bit1");
    xfer(1, 0, 2, 32'h2200_0008, 32'hFFFF_FFFE, 0, 0, "R4 alias clear bit2");
    xfer(0, 0, 2, 32'h2000_0000, 0, 32'h3355_AAC8, 0, "R4 word after clear");

    xfer(1, 0, 2, 32'h4000_0004, 32'h0, 0, 0, "R1 periph write");
    xfer(1, 0, 2, 32'h4200_00FC, 32'h1, 0, 0, "R2 alias set bit31 periph");
    check(last_addr == 32'h4000_0004, "R2 periph target", last_addr, 32'h4000_0004);
    xfer(0, 0, 2, 32'h4000_0004, 0, 32'h8000_0000, 0, "R2 periph word");

    xfer(1, 0, 2, 32'h2000_0004, 32'h0, 0, 0, "R1 clear word");
    xfer(1, 0, 0, 32'h2200_00A4, 32'h1, 0, 0, "R7 byte alias set bit9");
    check(last_addr == 32'h2000_0005 && last_size == 0, "R7 byte target",
          {last_addr[31:2], last_size}, {30'h0800_0001, 2'd0});
    xfer(0, 0, 2, 32'h2000_0004, 0, 32'h0000_0200, 0, "R7 word after byte set");
    xfer(0, 0, 1, 32'h2200_00A4, 0, 32'h1, 0, "R7 half alias read bit9");
    check(last_addr == 32'h2000_0004 && last_size == 1, "R7 half target", last_addr, 32'h2000_0004);

    begin
      int b0;
      b0 = beats;
      xfer(1, 0, 2, 32'h2200_0002, 32'h1, 0, 1, "R8 misaligned alias");
      check(beats == b0, "R8 no downstream beat", beats, b0);
    end
    xfer(0, 0, 2, 32'h2000_0000, 0, 32'h3355_AAC8, 0, "R8 word unchanged");

    xfer(0, 1, 2, 32'h2200_0008, 0, 32'hA5A5_0F0F, 0, "R9 fetch raw word");
    check(last_addr == 32'h2200_0008, "R9 fetch addr unchanged", last_addr, 32'h2200_0008);

    check(lock_bad == 0 && lock_pairs == 3, "R5 locked pairs", lock_pairs, 3);
    check(ready_bad == 0, "R6 ready low when busy", ready_bad, 0);
    check(hold_bad == 0, "R11 hold under stall", hold_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule